// File: doc/BRIEF.md
# Dual-Port Pin Change Interrupt Unit

This block watches two 8-bit input ports, A and B, and raises an interrupt for each port when an enabled pin meets its trigger condition. Each pin passes through a two-flop synchronizer. It can then be inverted by a per-bit polarity mask, and the result is the pin's logical value. Each pin has its own enable bit and its own trigger mode. In one mode the pin fires when its logical value differs from the value it had one clock earlier. In the other mode it fires for as long as its logical value differs from a programmed reference bit.

When a port's interrupt goes pending, the block copies the port's logical value into a capture register. It also records which pins caused the event in a cause-flag register. Both registers then hold until software reads the port value or the capture register of that port. The two interrupt lines can each follow their own port, or they can be ORed so that both lines react to either port. They can be driven active-low, active-high, or as an open-drain pull-down expressed through an output-enable.

Software reaches the registers through a single-cycle strobe interface. The read data is a combinational function of the address, and a read clears pending state only in the cycle the read strobe is high.

Top module: `ioc_dual_port`

## Requirements
- R1: Register map. Address bit 3 selects the port (0 = A, 1 = B). Address bits 2:0 select the register: 0 polarity mask, 1 pin enable, 2 reference value, 3 trigger mode, 4 port value, 5 capture, 6 cause flags, 7 shared line configuration. Reading register 4 returns the synchronized pin value XOR the polarity mask. A pin change first appears there two clock edges after it is applied.
- R2: A pin whose enable bit is 0 never sets its port's pending state or its cause flag, whatever its value does.
- R3: An enabled pin with mode bit 0 sets pending when its logical value differs from its logical value in the previous cycle.
- R4: An enabled pin with mode bit 1 sets pending while its logical value differs from its reference bit. If the mismatch remains after a clearing read, pending sets again on the next cycle.
- R5: When pending sets, the capture register loads the port's logical value. Capture holds while the port stays pending, even if the pins keep changing.
- R6: When pending sets, the cause-flag register loads exactly the pins that triggered. It is nonzero while pending, it is read-only, and writes to registers 4, 5 and 6 are ignored.
- R7: A read strobe on a port's register 4 or 5 clears that port's pending state and cause flags at that edge. A clear takes priority over a new trigger in the same cycle.
- R8: With config bit 0 = 0, line A reflects only port A and line B reflects only port B. With bit 0 = 1, each line is active when either port is pending.
- R9: With config bit 2 = 0 (push-pull), the output enables are 1. The line is high when active if config bit 1 = 1, and low when active if bit 1 = 0.
- R10: With config bit 2 = 1 (open-drain), the line data is 0 and the output enable is 1 only while the line is active.
- R11: After reset, all registers read 0, no port is pending, and both lines are inactive in active-low push-pull form (line 1, enable 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_a_i | input | 8 | Port A pin values, asynchronous |
| pin_b_i | input | 8 | Port B pin values, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears on port/capture reads) |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for the addressed register |
| irq_a_o | output | 1 | Interrupt line A data |
| irq_b_o | output | 1 | Interrupt line B data |
| irq_a_oe_o | output | 1 | Interrupt line A output enable |
| irq_b_oe_o | output | 1 | Interrupt line B output enable |

## Verification
Directed single-pin toggles on enabled and disabled pins separate the trigger path from the enable gating. Further changes applied while an interrupt is pending show whether the capture and cause flags stay frozen. A persistent reference mismatch across a clearing read tells the level-style mode apart from the edge-style mode by the one-cycle gap and then the re-trigger. Random mixes of enable, mode, reference and polarity masks, with a base value followed by a new value, check which pins the block blames and which value it captures when both modes are active on one port. The line tests sweep mirroring, polarity and open-drain with only port B pending, so that routing errors show on line A.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

    localparam int unsigned ADDR_W = 4;
    localparam int unsigned SEL_W  = 3;
    localparam int unsigned NPORT  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_INV  = 3'd0,
        SEL_IEN  = 3'd1,
        SEL_REF  = 3'd2,
        SEL_MODE = 3'd3,
        SEL_PORT = 3'd4,
        SEL_CAPT = 3'd5,
        SEL_FLAG = 3'd6,
        SEL_CFG  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic open_drain;
        logic act_hi;
        logic mirror;
    } irq_cfg_t;

endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/ioc_port_unit.sv
module ioc_port_unit
    import ioc_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [W-1:0]     pin_s_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [W-1:0]     wdata_i,
    output logic [W-1:0]     rdata_o,
    output logic             pend_o
);

    typedef struct packed {
        logic [W-1:0] inv;
        logic [W-1:0] ien;
        logic [W-1:0] refv;
        logic [W-1:0] mode;
        logic [W-1:0] prev;
        logic [W-1:0] capt;
        logic [W-1:0] flags;
        logic         pend;
    } port_st_t;

    port_st_t st_d, st_q;
    reg_sel_e sel;
    logic [W-1:0] pv;
    logic [W-1:0] hit;
    logic         clr;

    assign sel = reg_sel_e'(sel_i);

    always_comb begin
        pv  = pin_s_i ^ st_q.inv;
        hit = st_q.ien & ((st_q.mode & (pv ^ st_q.refv)) |
                          (~st_q.mode & (pv ^ st_q.prev)));
        clr = rd_i && ((sel == SEL_PORT) || (sel == SEL_CAPT));

        st_d      = st_q;
        st_d.prev = pv;

        if (wr_i) begin
            case (sel)
                SEL_INV:  st_d.inv  = wdata_i;
                SEL_IEN:  st_d.ien  = wdata_i;
                SEL_REF:  st_d.refv = wdata_i;
                SEL_MODE: st_d.mode = wdata_i;
                default:  ;
            endcase
        end

        if (clr) begin
            st_d.pend  = 1'b0;
            st_d.flags = '0;
        end else if (!st_q.pend && (|hit)) begin
            st_d.pend  = 1'b1;
            st_d.flags = hit;
            st_d.capt  = pv;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        case (sel)
            SEL_INV:  rdata_o = st_q.inv;
            SEL_IEN:  rdata_o = st_q.ien;
            SEL_REF:  rdata_o = st_q.refv;
            SEL_MODE: rdata_o = st_q.mode;
            SEL_PORT: rdata_o = pv;
            SEL_CAPT: rdata_o = st_q.capt;
            SEL_FLAG: rdata_o = st_q.flags;
            default:  rdata_o = '0;
        endcase
    end

    assign pend_o = st_q.pend;

    // R2: a fresh event never blames a pin that was disabled in the cycle it fired
    a_r2_only_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.pend) |-> ((st_q.flags & ~$past(st_q.ien)) == '0));

    // R5: capture frozen while the port stays pending
    a_r5_capt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(st_q.pend) && st_q.pend) |-> ($stable(st_q.capt) && $stable(st_q.flags)));

    // R6: pending always carries at least one cause
    a_r6_flags_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.pend |-> (st_q.flags != '0));

    // R7: clearing read wins at its edge
    a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && ((sel == SEL_PORT) || (sel == SEL_CAPT))) |=> !st_q.pend);

endmodule

// File: rtl/ioc_irq_out.sv
module ioc_irq_out
    import ioc_pkg::*;
(
    input  logic [NPORT-1:0] pend_i,
    input  irq_cfg_t         cfg_i,
    output logic [NPORT-1:0] line_o,
    output logic [NPORT-1:0] oe_o
);

    logic [NPORT-1:0] act;

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            act[i] = pend_i[i] | (cfg_i.mirror & (|pend_i));
            if (cfg_i.open_drain) begin
                line_o[i] = 1'b0;
                oe_o[i]   = act[i];
            end else begin
                line_o[i] = cfg_i.act_hi ? act[i] : ~act[i];
                oe_o[i]   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ioc_dual_port.sv
module ioc_dual_port
    import ioc_pkg::*;
#(
    parameter int unsigned W           = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [W-1:0]      pin_a_i,
    input  logic [W-1:0]      pin_b_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [W-1:0]      reg_wdata_i,
    output logic [W-1:0]      reg_rdata_o,
    output logic              irq_a_o,
    output logic              irq_b_o,
    output logic              irq_a_oe_o,
    output logic              irq_b_oe_o
);

    localparam int unsigned PORT_BIT = ADDR_W - 1;

    typedef struct packed {
        irq_cfg_t cfg;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NPORT-1:0][W-1:0] pin_raw, pin_sync, unit_rdata;
    logic [NPORT-1:0]        pend, line, oe;
    logic [SEL_W-1:0]        sel;
    logic                    port_sel;
    logic [W-1:0]            cfg_rd;

    assign sel        = reg_addr_i[SEL_W-1:0];
    assign port_sel   = reg_addr_i[PORT_BIT];
    assign pin_raw[0] = pin_a_i;
    assign pin_raw[1] = pin_b_i;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic hit_port;
        assign hit_port = (port_sel == 1'(p));

        ioc_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .async_i (pin_raw[p]),
            .sync_o  (pin_sync[p])
        );

        ioc_port_unit #(.W(W)) u_unit (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .pin_s_i (pin_sync[p]),
            .wr_i    (reg_wr_i && hit_port),
            .rd_i    (reg_rd_i && hit_port),
            .sel_i   (sel),
            .wdata_i (reg_wdata_i),
            .rdata_o (unit_rdata[p]),
            .pend_o  (pend[p])
        );
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr_i && (reg_sel_e'(sel) == SEL_CFG)) begin
            st_d.cfg.mirror     = reg_wdata_i[0];
            st_d.cfg.act_hi     = reg_wdata_i[1];
            st_d.cfg.open_drain = reg_wdata_i[2];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        cfg_rd    = '0;
        cfg_rd[0] = st_q.cfg.mirror;
        cfg_rd[1] = st_q.cfg.act_hi;
        cfg_rd[2] = st_q.cfg.open_drain;
        reg_rdata_o = (reg_sel_e'(sel) == SEL_CFG) ? cfg_rd : unit_rdata[port_sel];
    end

    ioc_irq_out u_irq (
        .pend_i (pend),
        .cfg_i  (st_q.cfg),
        .line_o (line),
        .oe_o   (oe)
    );

    assign irq_a_o    = line[0];
    assign irq_b_o    = line[1];
    assign irq_a_oe_o = oe[0];
    assign irq_b_oe_o = oe[1];

    // R8: mirrored lines always agree
    a_r8_mirror_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cfg.mirror |-> ((irq_a_o == irq_b_o) && (irq_a_oe_o == irq_b_oe_o)));

    // R8: unmirrored active-high line A follows port A only
    a_r8_line_a_own: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.cfg.mirror && !st_q.cfg.open_drain && st_q.cfg.act_hi) |-> (irq_a_o == pend[0]));

    // R9: push-pull keeps both enables on
    a_r9_pushpull_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.cfg.open_drain |-> (irq_a_oe_o && irq_b_oe_o));

    // R10: open-drain never drives a high level
    a_r10_od_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cfg.open_drain |-> (!irq_a_o && !irq_b_o));

endmodule

// File: tb/ioc_dual_port_bench.sv
module ioc_dual_port_bench;

    localparam int CLK_PERIOD = 10;

    localparam logic [3:0] A_INV = 4'h0, A_IEN = 4'h1, A_REF = 4'h2, A_MODE = 4'h3;
    localparam logic [3:0] A_PORT = 4'h4, A_CAPT = 4'h5, A_FLAG = 4'h6, CFG = 4'h7;
    localparam logic [3:0] B_IEN = 4'h9, B_PORT = 4'hC, B_CAPT = 4'hD, B_FLAG = 4'hE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pa = '0, pb = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_a, irq_b, oe_a, oe_b;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ioc_dual_port u_ioc_dual_port (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pin_a_i     (pa),
        .pin_b_i     (pb),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_a_o     (irq_a),
        .irq_b_o     (irq_b),
        .irq_a_oe_o  (oe_a),
        .irq_b_oe_o  (oe_b)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk); rd = 1'b1; addr = a; #1 v = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; #1 v = rdata;
    endtask

    task automatic set_pins(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk); pa = a; pb = b;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_hit(input logic [7:0] v, input logic [7:0] prv,
                                           input logic [7:0] en, input logic [7:0] md,
                                           input logic [7:0] rf);
        return en & ((md & (v ^ rf)) | (~md & (v ^ prv)));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd2718));
        cycles(3);
        rst_n = 1'b1;

        // R11 reset state
        peek(A_INV, v);  chk("R11 inv A", v, 8'h00);
        peek(B_IEN, v);  chk("R11 ien B", v, 8'h00);
        peek(CFG, v);    chk("R11 cfg", v, 8'h00);
        chk("R11 lines", {4'h0, irq_a, irq_b, oe_a, oe_b}, 8'h0F);

        // R1 two-edge latency and polarity mask
        addr = B_PORT;
        set_pins(8'h00, 8'h55);
        @(negedge clk); #1 chk("R1 one edge", rdata, 8'h00);
        @(negedge clk); #1 chk("R1 two edges", rdata, 8'h55);
        wr_reg(A_INV, 8'h0F);
        set_pins(8'h3C, 8'h55);
        cycles(3);
        peek(A_PORT, v); chk("R1 inverted port", v, 8'h33);

        // R2 disabled pins ignored
        set_pins(8'hC3, 8'hAA);
        cycles(4);
        peek(A_FLAG, v); chk("R2 flags A", v, 8'h00);
        peek(B_FLAG, v); chk("R2 flags B", v, 8'h00);
        chk("R2 lines", {6'h0, irq_a, irq_b}, 8'h03);

        // R3 change mode
        wr_reg(A_IEN, 8'hFF);
        set_pins(8'hC2, 8'hAA);
        cycles(4);
        peek(A_FLAG, v); chk("R3 flags", v, 8'h01);
        chk("R3 line A active", {7'h0, irq_a}, 8'h00);
        peek(A_CAPT, v); chk("R5 capture", v, 8'hCD);

        // R5 hold while pending
        set_pins(8'h02, 8'hAA);
        cycles(4);
        peek(A_CAPT, v); chk("R5 capture held", v, 8'hCD);
        peek(A_FLAG, v); chk("R6 flags held", v, 8'h01);

        // R7 clear by capture read and by port read
        rd_reg(A_CAPT, v); chk("R7 capt read", v, 8'hCD);
        chk("R7 line A idle", {7'h0, irq_a}, 8'h01);
        peek(A_FLAG, v); chk("R7 flags cleared", v, 8'h00);
        set_pins(8'h03, 8'hAA);
        cycles(4);
        chk("R3 second event", {7'h0, irq_a}, 8'h00);
        rd_reg(A_PORT, v); chk("R7 port read", v, 8'h0C);
        chk("R7 line A idle after port read", {7'h0, irq_a}, 8'h01);

        // R4 reference mode re-triggers after clear
        wr_reg(A_IEN, 8'h01);
        wr_reg(A_MODE, 8'h01);
        wr_reg(A_REF, 8'h00);
        wr_reg(A_INV, 8'h00);
        cycles(3);
        chk("R4 ref mismatch", {7'h0, irq_a}, 8'h00);
        rd_reg(A_CAPT, v); chk("R4 capture", v, 8'h03);
        chk("R4 cleared", {7'h0, irq_a}, 8'h01);
        @(negedge clk);
        chk("R4 refire", {7'h0, irq_a}, 8'h00);
        wr_reg(A_IEN, 8'h00);
        rd_reg(A_CAPT, v);
        cycles(2);
        chk("R4 off", {7'h0, irq_a}, 8'h01);

        // R8 routing and mirroring with only port B pending
        wr_reg(B_IEN, 8'h01);
        set_pins(8'h03, 8'hAB);
        cycles(4);
        chk("R8 own routing", {6'h0, irq_a, irq_b}, 8'h02);
        wr_reg(CFG, 8'h01);
        chk("R8 mirrored", {6'h0, irq_a, irq_b}, 8'h00);
        wr_reg(CFG, 8'h00);
        chk("R8 unmirrored", {6'h0, irq_a, irq_b}, 8'h02);

        // R9 active-high
        wr_reg(CFG, 8'h02);
        chk("R9 active high", {6'h0, irq_a, irq_b}, 8'h01);

        // R10 open-drain, R6 read-only flags
        wr_reg(CFG, 8'h04);
        chk("R10 od", {4'h0, irq_a, irq_b, oe_a, oe_b}, 8'h01);
        wr_reg(B_FLAG, 8'hFF);
        peek(B_FLAG, v); chk("R6 flag write ignored", v, 8'h01);
        wr_reg(B_CAPT, 8'h00);
        rd_reg(B_CAPT, v); chk("R6 capt write ignored", v, 8'hAB);
        chk("R10 od released", {4'h0, irq_a, irq_b, oe_a, oe_b}, 8'h00);
        wr_reg(CFG, 8'h00);
        wr_reg(B_IEN, 8'h00);

        // R3 R4 R5 R6 randomized mixes on port A
        for (int it = 0; it < 40; it++) begin
            logic [7:0] base, nv, en, md, rf, iv, hb, hn, ef, ec;
            base = 8'($urandom); nv = 8'($urandom); en = 8'($urandom);
            md = 8'($urandom); rf = 8'($urandom); iv = 8'($urandom);
            if (it % 4 == 0) md = 8'h00;
            if (it % 4 == 1) md = 8'hFF;
            wr_reg(A_IEN, 8'h00);
            wr_reg(A_INV, iv);
            wr_reg(A_MODE, md);
            wr_reg(A_REF, rf);
            set_pins(base ^ iv, pb);
            cycles(4);
            wr_reg(A_IEN, en);
            cycles(1);
            rd_reg(A_CAPT, v);
            pa = nv ^ iv;
            cycles(5);
            hb = en & md & (base ^ rf);
            hn = exp_hit(nv, base, en, md, rf);
            if (hb != 0) begin ef = hb; ec = base; end
            else begin ef = hn; ec = nv; end
            peek(A_FLAG, v); chk("R6 random flags", v, ef);
            chk("R3/R4 random line", {7'h0, irq_a}, {7'h0, ef == 8'h00});
            if (ef != 0) begin
                peek(A_CAPT, v); chk("R5 random capture", v, ec);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule